// File: doc/BRIEF.md
# Escaped Byte-Stream Packet Deframer

This block sits on the receive side of a byte-wide link. It takes one received byte per accepted cycle and recovers packets from a stream that uses three reserved byte values. 0xFE opens a packet and 0xFF closes one. 0xFD is an escape prefix: the byte that follows it rebuilds one reserved value as payload. Because a correctly encoded stream never carries a raw 0xFE or 0xFF inside a packet, either of them is a safe point to regain sync after a fault.

Payload bytes leave on a valid/ready stream. The first byte of a packet carries a start-of-packet flag and the last carries an end-of-packet flag. The block holds back one payload byte so that it can mark that byte as last when the end code arrives. Malformed escapes and packets cut short by a new start code raise a one-cycle framing-error pulse, and the damaged packet is dropped.

Back-pressure rules: `in_ready` follows `out_ready` within the same cycle, so when the consumer stalls, no input byte is accepted. While `out_valid` is high and `out_ready` is low, the output beat stays unchanged. A byte is consumed only on a cycle where `in_valid` and `in_ready` are both high. One input byte produces at most one output beat, so no byte is lost or duplicated.

Top module: `esc_deframer`

## Requirements
- R1: While no packet is open, every byte except 0xFE is dropped without output or error, including 0xFF and 0xFD. 0xFE opens a packet.
- R2: Inside a packet, the byte values 0x00 to 0xFC appear unchanged on out_data.
- R3: Inside a packet, the escape pairs 0xFD 0x0D, 0xFD 0x0E and 0xFD 0x0F each produce one payload byte, 0xFD, 0xFE and 0xFF respectively.
- R4: If the byte after 0xFD is anything other than 0x0D, 0x0E, 0x0F or 0xFE, frame_err is high for exactly one cycle, in the cycle after that byte is accepted. The held byte is discarded, and nothing more is output until the next 0xFE.
- R5: A 0xFE accepted while a packet is open, including right after 0xFD, pulses frame_err for one cycle, discards the held byte and opens a new packet.
- R6: The first payload beat of a packet has out_sop=1. The beat whose byte came just before the 0xFF has out_eop=1. A one-byte packet has both flags on its single beat.
- R7: 0xFE followed directly by 0xFF produces no beat and no frame_err.
- R8: in_ready is low whenever out_ready is low. A stalled beat holds its data and flags. The sequence of beats does not depend on the stall pattern.
- R9: After reset, out_valid and frame_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Received byte is present |
| in_ready | output | 1 | Block accepts a byte this cycle |
| in_data | input | 8 | Received byte |
| out_valid | output | 1 | Payload beat is present |
| out_ready | input | 1 | Consumer takes the beat |
| out_data | output | 8 | Payload byte |
| out_sop | output | 1 | First byte of a packet |
| out_eop | output | 1 | Last byte of a packet |
| frame_err | output | 1 | One-cycle pulse for a malformed escape or an aborted packet |

## Verification
The assertions check on every cycle that a stalled beat stays stable, that beats and error pulses only follow an accepted input byte, that an error cycle carries no beat, and that start and end flags nest correctly (no start flag inside an open packet, no body beat outside one). The bench scenarios are the only place where the decoded byte values are compared: pass-through, escape rebuilding, dropping of idle bytes, recovery after a bad escape or an abort, empty packets, and identical output under a stalling consumer.

// File: rtl/esc_deframer_pkg.sv
package esc_deframer_pkg;
  localparam int BYTE_W = 8;
  localparam int N_RESERVED = 3;

  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t START_C    = 8'hFE;
  localparam byte_t END_C      = 8'hFF;
  localparam byte_t ESC_C      = 8'hFD;
  // escape suffixes: base+0 -> ESC_C, base+1 -> START_C, base+2 -> END_C
  localparam byte_t SFX_BASE   = 8'h0D;

  typedef enum logic [1:0] {ST_IDLE, ST_BODY, ST_ESC} state_e;
  typedef enum logic [1:0] {CL_DATA, CL_START, CL_END, CL_ESC} class_e;

  typedef struct packed {
    byte_t data;
    logic  sop;
    logic  eop;
  } beat_t;

  function automatic byte_t reserved_code(input int idx);
    case (idx)
      0:       reserved_code = ESC_C;
      1:       reserved_code = START_C;
      default: reserved_code = END_C;
    endcase
  endfunction
endpackage

// File: rtl/esc_deframer_classify.sv
module esc_deframer_classify
  import esc_deframer_pkg::*;
(
  input  byte_t  byte_i,
  output class_e cls_o,
  output logic   sfx_ok_o,
  output byte_t  sfx_val_o
);
  logic [N_RESERVED-1:0] hit_raw;
  logic [N_RESERVED-1:0] hit_sfx;

  for (genvar g = 0; g < N_RESERVED; g++) begin : g_cmp
    assign hit_raw[g] = (byte_i == reserved_code(g));
    assign hit_sfx[g] = (byte_i == byte_t'(SFX_BASE + byte_t'(g)));
  end

  always_comb begin
    if (hit_raw[1])      cls_o = CL_START;
    else if (hit_raw[2]) cls_o = CL_END;
    else if (hit_raw[0]) cls_o = CL_ESC;
    else                 cls_o = CL_DATA;
  end

  always_comb begin
    sfx_ok_o  = |hit_sfx;
    sfx_val_o = '0;
    for (int i = 0; i < N_RESERVED; i++) begin
      if (hit_sfx[i]) sfx_val_o = reserved_code(i);
    end
  end
endmodule

// File: rtl/esc_deframer_fsm.sv
module esc_deframer_fsm
  import esc_deframer_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   take_i,
  input  byte_t  byte_i,
  input  class_e cls_i,
  input  logic   sfx_ok_i,
  input  byte_t  sfx_val_i,
  output logic   push_o,
  output byte_t  push_data_o,
  output logic   open_o,
  output logic   close_o,
  output logic   drop_o,
  output logic   err_o
);
  state_e state_q, state_d;
  logic   err_c, err_q;

  always_comb begin
    state_d     = state_q;
    push_o      = 1'b0;
    push_data_o = byte_i;
    open_o      = 1'b0;
    close_o     = 1'b0;
    drop_o      = 1'b0;
    err_c       = 1'b0;
    if (take_i) begin
      unique case (state_q)
        ST_IDLE: begin
          if (cls_i == CL_START) begin
            open_o  = 1'b1;
            state_d = ST_BODY;
          end
        end
        ST_BODY: begin
          unique case (cls_i)
            CL_START: begin
              err_c  = 1'b1;
              drop_o = 1'b1;
              open_o = 1'b1;
            end
            CL_END: begin
              close_o = 1'b1;
              state_d = ST_IDLE;
            end
            CL_ESC:  state_d = ST_ESC;
            default: push_o = 1'b1;
          endcase
        end
        default: begin
          if (cls_i == CL_START) begin
            err_c   = 1'b1;
            drop_o  = 1'b1;
            open_o  = 1'b1;
            state_d = ST_BODY;
          end else if (sfx_ok_i) begin
            push_o      = 1'b1;
            push_data_o = sfx_val_i;
            state_d     = ST_BODY;
          end else begin
            err_c   = 1'b1;
            drop_o  = 1'b1;
            state_d = ST_IDLE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_c;
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/esc_deframer_holdback.sv
module esc_deframer_holdback
  import esc_deframer_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  advance_i,
  input  logic  push_i,
  input  byte_t push_data_i,
  input  logic  open_i,
  input  logic  close_i,
  input  logic  drop_i,
  output logic  out_vld_o,
  output beat_t out_beat_o
);
  logic  held_vld_q;
  byte_t held_data_q;
  logic  held_sop_q;
  logic  first_q;
  logic  emit;
  beat_t ebeat;
  beat_t out_q;
  logic  out_vld_q;

  always_comb begin
    ebeat.data = held_data_q;
    ebeat.sop  = held_sop_q;
    ebeat.eop  = close_i;
    emit       = held_vld_q && (push_i || close_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_vld_q  <= 1'b0;
      held_data_q <= '0;
      held_sop_q  <= 1'b0;
      first_q     <= 1'b0;
    end else begin
      if (push_i) begin
        held_vld_q  <= 1'b1;
        held_data_q <= push_data_i;
        held_sop_q  <= first_q;
        first_q     <= 1'b0;
      end else if (close_i || drop_i) begin
        held_vld_q <= 1'b0;
      end
      if (open_i) first_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld_q <= 1'b0;
      out_q     <= '0;
    end else if (advance_i) begin
      out_vld_q <= emit;
      if (emit) out_q <= ebeat;
    end
  end

  assign out_vld_o  = out_vld_q;
  assign out_beat_o = out_q;
endmodule

// File: rtl/esc_deframer.sv
module esc_deframer
  import esc_deframer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_sop,
  output logic       out_eop,
  output logic       frame_err
);
  class_e cls;
  logic   sfx_ok;
  byte_t  sfx_val;
  logic   take;
  logic   push, open_p, close_p, drop_p;
  byte_t  push_data;
  beat_t  beat;

  assign in_ready = out_ready;
  assign take     = in_valid && out_ready;

  esc_deframer_classify u_cls (
    .byte_i    (in_data),
    .cls_o     (cls),
    .sfx_ok_o  (sfx_ok),
    .sfx_val_o (sfx_val)
  );

  esc_deframer_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_i      (take),
    .byte_i      (in_data),
    .cls_i       (cls),
    .sfx_ok_i    (sfx_ok),
    .sfx_val_i   (sfx_val),
    .push_o      (push),
    .push_data_o (push_data),
    .open_o      (open_p),
    .close_o     (close_p),
    .drop_o      (drop_p),
    .err_o       (frame_err)
  );

  esc_deframer_holdback u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .advance_i   (out_ready),
    .push_i      (push),
    .push_data_i (push_data),
    .open_i      (open_p),
    .close_i     (close_p),
    .drop_i      (drop_p),
    .out_vld_o   (out_valid),
    .out_beat_o  (beat)
  );

  assign out_data = beat.data;
  assign out_sop  = beat.sop;
  assign out_eop  = beat.eop;
endmodule

// File: rtl/esc_deframer_chk.sv
module esc_deframer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_sop,
  input logic       out_eop,
  input logic       frame_err
);
  logic open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) open_q <= 1'b0;
    else if (out_valid && out_ready) open_q <= !out_eop;
    else if (frame_err) open_q <= 1'b0;
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)); // R8
  AST_BEAT_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready)); // R8
  AST_ERR_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> $past(in_valid && in_ready)); // R4
  AST_ERR_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> !out_valid); // R5
  AST_SOP_WHEN_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sop |-> !open_q); // R6
  AST_BODY_WHEN_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_sop |-> open_q); // R6
endmodule

bind esc_deframer esc_deframer_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_sop   (out_sop),
  .out_eop   (out_eop),
  .frame_err (frame_err)
);

// File: tb/esc_deframer_tb_top.sv
`timescale 1ns/1ps
module esc_deframer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;
  logic       out_sop, out_eop, frame_err;

  int n_cmp = 0, n_bad = 0, err_cnt = 0, rdy_viol = 0, cyc = 0;
  bit bp_en = 1'b0;
  logic [9:0] got_q[$];
  logic [9:0] exp_q[$];
  logic [7:0] tx_q[$];

  always #4 clk = ~clk;

  esc_deframer dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
    .frame_err(frame_err)
  );

  always @(negedge clk) begin
    cyc++;
    out_ready = bp_en ? ((cyc % 3) != 0) : 1'b1;
  end

  always begin
    @(negedge clk);
    #1;
    if (rst_n) begin
      if (out_valid && out_ready) got_q.push_back({out_sop, out_eop, out_data});
      if (frame_err) err_cnt++;
      if (!out_ready && in_ready) rdy_viol++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ex(input logic [7:0] b, input logic s, input logic e);
    exp_q.push_back({s, e, b});
  endtask

  task automatic start_case();
    got_q.delete(); exp_q.delete(); tx_q.delete(); err_cnt = 0;
  endtask

  task automatic send_all();
    while (tx_q.size() > 0) begin
      in_data = tx_q.pop_front();
      in_valid = 1'b1;
      #1;
      while (!in_ready) begin
        @(negedge clk);
        #1;
      end
      @(negedge clk);
      in_valid = 1'b0;
    end
    repeat (12) @(negedge clk);
  endtask

  task automatic compare(input string req, input int exp_err);
    chk({req, " beat count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk({req, " beat"}, {22'd0, got_q[i]}, {22'd0, exp_q[i]});
    chk({req, " error pulses"}, err_cnt, exp_err);
  endtask

  task automatic t_idle_drop();   // R1
    start_case();
    tx_q = '{8'h41, 8'hFF, 8'hFD, 8'h05, 8'h0E};
    send_all();
    compare("R1 idle drop", 0);
  endtask

  task automatic t_plain();       // R2 R6
    start_case();
    tx_q = '{8'hFE, 8'h00, 8'h7A, 8'hFC, 8'hFF};
    ex(8'h00, 1, 0); ex(8'h7A, 0, 0); ex(8'hFC, 0, 1);
    send_all();
    compare("R2 R6 plain bytes", 0);
  endtask

  task automatic t_escape();      // R3
    start_case();
    tx_q = '{8'hFE, 8'hFD, 8'h0D, 8'hFD, 8'h0E, 8'h33, 8'hFD, 8'h0F, 8'hFF};
    ex(8'hFD, 1, 0); ex(8'hFE, 0, 0); ex(8'h33, 0, 0); ex(8'hFF, 0, 1);
    send_all();
    compare("R3 escape pairs", 0);
  endtask

  task automatic t_single();      // R6
    start_case();
    tx_q = '{8'hFE, 8'h55, 8'hFF};
    ex(8'h55, 1, 1);
    send_all();
    compare("R6 single byte", 0);
  endtask

  task automatic t_empty();       // R7
    start_case();
    tx_q = '{8'hFE, 8'hFF};
    send_all();
    compare("R7 empty packet", 0);
  endtask

  task automatic t_bad_escape();  // R4
    start_case();
    tx_q = '{8'hFE, 8'h11, 8'h22, 8'hFD, 8'h40, 8'h33, 8'hFF, 8'h44,
             8'hFE, 8'h66, 8'hFF};
    ex(8'h11, 1, 0); ex(8'h66, 1, 1);
    send_all();
    compare("R4 bad escape", 1);
  endtask

  task automatic t_abort();       // R5
    start_case();
    tx_q = '{8'hFE, 8'h10, 8'h20, 8'hFE, 8'h30, 8'hFF,
             8'hFE, 8'h70, 8'hFD, 8'hFE, 8'h71, 8'hFF};
    ex(8'h10, 1, 0); ex(8'h30, 1, 1); ex(8'h71, 1, 1);
    send_all();
    compare("R5 abort", 2);
  endtask

  task automatic t_stall();       // R8
    logic [7:0] b;
    start_case();
    rdy_viol = 0;
    bp_en = 1'b1;
    tx_q.push_back(8'hFE);
    for (int i = 0; i < 20; i++) begin
      if (i % 5 == 1) b = 8'(8'hFD + (i / 5) % 3);
      else b = 8'(i * 11);
      if (b >= 8'hFD) begin
        tx_q.push_back(8'hFD);
        tx_q.push_back(8'(b - 8'hF0));
      end else tx_q.push_back(b);
      ex(b, i == 0, i == 19);
    end
    tx_q.push_back(8'hFF);
    send_all();
    bp_en = 1'b0;
    repeat (2) @(negedge clk);
    compare("R8 stalled stream", 0);
    chk("R8 in_ready low while out_ready low", rdy_viol, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R9 reset out_valid", out_valid, 0);
    chk("R9 reset frame_err", frame_err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 idle out_valid", out_valid, 0);
    t_idle_drop();
    t_plain();
    t_escape();
    t_single();
    t_empty();
    t_bad_escape();
    t_abort();
    t_stall();
    t_plain();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule